// File: doc/BRIEF.md
# Clause-22 Management Interface Master

This block drives the two-wire PHY management bus. Software uses a small register window to set up one transaction: the PHY address, the register number inside the PHY, the direction and, for a write, a 16-bit value. It then starts the transfer through a control word. The block generates the management clock by dividing the system clock. It shifts out the full frame and, for a read, releases the data line and captures the 16 bits the PHY returns.

Completion uses a single busy bit. Software sets it to start a transfer, the hardware holds it while the frame is on the wire, and the hardware clears it at the end. Software polls that bit, then reads the result word. A separate enable bit in the same control word gates starts. A start request is honoured only when the write that carries it also leaves the enable bit set.

The register window has four word slots selected by a 2-bit index: target (0), write value (1), read result (2) and control (3). Transfers always use the full 32-bit preamble.

Top module: `mdio_master`

## Requirements
- R1: After reset the control word reads 0, the management clock output is low and the data line is not driven.
- R2: The target slot (index 0) holds an 11-bit value: bits 4:0 are the PHY register number, bits 9:5 are the PHY address, and bit 10 selects read (1) or write (0). The write-value slot (index 1) holds 16 bits. Both read back exactly what was written.
- R3: A control write with bit 0 set starts a transfer only if bit 3 (enable) of the same written value is 1. Otherwise the busy bit stays 0 and no frame appears on the bus.
- R4: Every frame is driven most significant bit first. It carries 32 ones, then start bits 01, then opcode 10 for a read or 01 for a write, then the 5-bit PHY address, then the 5-bit register number.
- R5: On a write, the master drives turnaround bits 10 and then the 16 bits of the write value, so all 64 bits of the frame are driven.
- R6: On a read, the master stops driving the data line for both turnaround bits and for all 16 data bits.
- R7: On a read, the 16 bits sampled from the line appear in the read-result slot (index 2), first sampled bit as bit 15, no later than the cycle in which the busy bit reads 0 again.
- R8: Control bit 0 reads 1 from the cycle after an accepted start until the frame ends. It then clears by itself within 66 management clock periods plus 4 system cycles. While it is 0, the data line is not driven.
- R9: The management clock has a period of CLK_DIV system cycles at 50 % duty. The data line and its drive enable change only on a falling edge of the management clock, and the line is sampled on the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register slot index |
| reg_wr | input | 1 | Write strobe for the selected slot |
| reg_wdata | input | 16 | Value to write |
| reg_rdata | output | 16 | Current contents of the selected slot |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Data value driven toward the PHY |
| mdio_oe | output | 1 | Drive enable for the data line (0 = released) |
| mdio_in | input | 1 | Data value seen on the line |

## Verification
Most internal faults show up directly on the serial line. A miscounted bit index shifts the opcode, the address fields or the turnaround within one frame, so the frame compare catches it as soon as that frame ends. A wrong release point shows as a drive-enable mismatch on a turnaround or data bit. A bad capture shift shows up in the result slot as soon as busy falls. A busy flag that is stuck or leaks past a disabled start is caught within a few hundred cycles, either by the completion bound or by an unexpected frame on the line.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PRE_BITS   = 32;
    localparam int DATA_W     = 16;
    localparam int FIELD_W    = 5;
    localparam int REG_W      = 16;
    localparam int FRAME_BITS = PRE_BITS + 4 + 2 * FIELD_W + 2 + DATA_W;
    localparam int TA_POS     = PRE_BITS + 4 + 2 * FIELD_W;
    localparam int DATA_POS   = TA_POS + 2;
    localparam int IDX_W      = $clog2(FRAME_BITS + 1);
    localparam int BUSY_BIT   = 0;
    localparam int EN_BIT     = 3;

    typedef logic [IDX_W-1:0] idx_t;

    typedef enum logic [1:0] {
        SLOT_TARGET = 2'd0,
        SLOT_WVAL   = 2'd1,
        SLOT_RVAL   = 2'd2,
        SLOT_CTRL   = 2'd3
    } slot_e;

    typedef struct packed {
        logic               rd;
        logic [FIELD_W-1:0] phy;
        logic [FIELD_W-1:0] regn;
    } target_t;

    typedef enum logic {ENG_IDLE, ENG_RUN} eng_state_e;

    function automatic logic [FRAME_BITS-1:0] build_frame(target_t t, logic [DATA_W-1:0] d);
        logic [1:0] op;
        logic [1:0] ta;
        logic [DATA_W-1:0] body;
        op   = t.rd ? 2'b10 : 2'b01;
        ta   = t.rd ? 2'b11 : 2'b10;
        body = t.rd ? '0 : d;
        return {{PRE_BITS{1'b1}}, 2'b01, op, t.phy, t.regn, ta, body};
    endfunction

endpackage

// File: rtl/mdio_tick_gen.sv
module mdio_tick_gen #(
    parameter int CLK_DIV = 8
) (
    input  logic clk,
    input  logic rst,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int HALF = (CLK_DIV < 2) ? 1 : CLK_DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap      = (cnt == CW'(HALF - 1));
    assign rise_tick = wrap && !mdc;
    assign fall_tick = wrap && mdc;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  target_t           target,
    input  logic [DATA_W-1:0] wval,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              mdio_in,
    output logic              mdio_out,
    output logic              mdio_oe,
    output logic              done,
    output logic [DATA_W-1:0] rval
);
    eng_state_e              st;
    idx_t                    idx;
    logic [FRAME_BITS-1:0]   frame_q;
    logic                    is_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ENG_IDLE;
            idx      <= '0;
            frame_q  <= '0;
            is_rd    <= 1'b0;
            mdio_out <= 1'b1;
            mdio_oe  <= 1'b0;
            done     <= 1'b0;
            rval     <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                ENG_IDLE: begin
                    if (start) begin
                        st      <= ENG_RUN;
                        idx     <= '0;
                        frame_q <= build_frame(target, wval);
                        is_rd   <= target.rd;
                    end
                end
                ENG_RUN: begin
                    if (fall_tick) begin
                        if (idx == idx_t'(FRAME_BITS)) begin
                            st       <= ENG_IDLE;
                            mdio_oe  <= 1'b0;
                            mdio_out <= 1'b1;
                            done     <= 1'b1;
                        end else begin
                            mdio_out <= frame_q[FRAME_BITS-1];
                            frame_q  <= {frame_q[FRAME_BITS-2:0], 1'b0};
                            mdio_oe  <= !(is_rd && idx >= idx_t'(TA_POS));
                            idx      <= idx + 1'b1;
                        end
                    end
                    if (rise_tick && is_rd && idx > idx_t'(DATA_POS))
                        rval <= {rval[DATA_W-2:0], mdio_in};
                end
                default: st <= ENG_IDLE;
            endcase
        end
    end

    AST_READ_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (st == ENG_RUN && is_rd && idx > idx_t'(TA_POS)) |-> !mdio_oe); // R6

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int CLK_DIV = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       reg_addr,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             mdc,
    output logic             mdio_out,
    output logic             mdio_oe,
    input  logic             mdio_in
);
    target_t           target_q;
    logic [DATA_W-1:0] wval_q;
    logic [DATA_W-1:0] rval_q;
    logic              en_q;
    logic              busy_q;
    logic              start;
    logic              rise_tick;
    logic              fall_tick;
    logic              eng_done;
    logic [DATA_W-1:0] eng_rval;
    slot_e             slot;

    assign slot  = slot_e'(reg_addr);
    assign start = reg_wr && slot == SLOT_CTRL && reg_wdata[BUSY_BIT]
                   && reg_wdata[EN_BIT] && !busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            target_q <= '0;
            wval_q   <= '0;
            rval_q   <= '0;
            en_q     <= 1'b0;
            busy_q   <= 1'b0;
        end else begin
            if (reg_wr) begin
                case (slot)
                    SLOT_TARGET: target_q <= target_t'(reg_wdata[$bits(target_t)-1:0]);
                    SLOT_WVAL:   wval_q   <= reg_wdata[DATA_W-1:0];
                    SLOT_CTRL:   en_q     <= reg_wdata[EN_BIT];
                    default:     ;
                endcase
            end
            if (start)
                busy_q <= 1'b1;
            else if (eng_done)
                busy_q <= 1'b0;
            if (eng_done)
                rval_q <= eng_rval;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (slot)
            SLOT_TARGET: reg_rdata[$bits(target_t)-1:0] = target_q;
            SLOT_WVAL:   reg_rdata[DATA_W-1:0] = wval_q;
            SLOT_RVAL:   reg_rdata[DATA_W-1:0] = rval_q;
            SLOT_CTRL: begin
                reg_rdata[BUSY_BIT] = busy_q;
                reg_rdata[EN_BIT]   = en_q;
            end
            default: ;
        endcase
    end

    mdio_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
        .clk       (clk),
        .rst       (rst),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_engine u_eng (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .target    (target_q),
        .wval      (wval_q),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_in   (mdio_in),
        .mdio_out  (mdio_out),
        .mdio_oe   (mdio_oe),
        .done      (eng_done),
        .rval      (eng_rval)
    );

    AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> en_q); // R3
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !eng_done) |=> busy_q); // R8
    AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> !mdio_oe); // R8
    AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (mdio_out != $past(mdio_out) || mdio_oe != $past(mdio_oe))
            |-> ($past(mdc) && !mdc)); // R9

endmodule

// File: tb/mdio_master_test.sv
module mdio_master_test;
    localparam int DIV    = 8;
    localparam int PERIOD = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  reg_addr = 2'd0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        mdc, mdio_out, mdio_oe, mdio_in;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        logic        rd;
        logic [63:0] bits;
        logic [63:0] oe;
        logic [15:0] resp;
    } exp_t;
    exp_t exp_q[$];

    always #(PERIOD/2) clk = ~clk;

    mdio_master #(.CLK_DIV(DIV)) uut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // Scoreboard driver: pushes the expected frame, starts and waits
    task automatic txn(input logic r, input logic [4:0] phy, input logic [4:0] rn,
                       input logic [15:0] wv, input logic [15:0] resp);
        exp_t e;
        logic [15:0] v;
        int waited;
        e.rd   = r;
        e.resp = resp;
        e.bits = {32'hFFFF_FFFF, 2'b01, (r ? 2'b10 : 2'b01), phy, rn,
                  (r ? 2'b00 : 2'b10), (r ? 16'h0 : wv)};
        e.oe   = r ? {{46{1'b1}}, 18'b0} : {64{1'b1}};
        exp_q.push_back(e);
        wr(2'd0, {5'b0, r, phy, rn});
        wr(2'd1, wv);
        wr(2'd3, 16'h0009);
        rd(2'd3, v);
        check(v[0] == 1'b1, "R8 busy after start", 64'(v), 64'h9);
        waited = 0;
        while (v[0] && waited < 66 * DIV + 4) begin
            @(negedge clk);
            waited++;
            rd(2'd3, v);
        end
        check(v[0] == 1'b0, "R8 busy clears in bound", 64'(waited), 64'(66 * DIV + 4));
        if (r) begin
            rd(2'd2, v);
            check(v == resp, "R7 read result", 64'(v), 64'(resp));
        end
    endtask

    // Scoreboard monitor with a simple PHY model
    initial begin
        logic [63:0] cap_v, cap_oe;
        bit in_frame;
        int k;
        exp_t cur;
        mdio_in = 1'b1;
        in_frame = 0;
        k = 0;
        cap_v = '0;
        cap_oe = '0;
        forever begin
            @(posedge mdc);
            #1;
            if (!in_frame && mdio_oe) begin
                in_frame = 1;
                k = 0;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected frame", 64'(1), 64'(0));
                    cur.rd = 0; cur.bits = '0; cur.oe = '1; cur.resp = '0;
                end else begin
                    cur = exp_q.pop_front();
                end
            end
            if (in_frame) begin
                cap_v[63-k]  = mdio_out;
                cap_oe[63-k] = mdio_oe;
                if (cur.rd && k >= 47 && k < 63) mdio_in = cur.resp[15-(k-47)];
                else mdio_in = 1'b1;
                k++;
                if (k == 64) begin
                    in_frame = 0;
                    check(cap_v[63:18] == cur.bits[63:18], "R4 frame header",
                          {18'b0, cap_v[63:18]}, {18'b0, cur.bits[63:18]});
                    check(cap_oe == cur.oe, cur.rd ? "R6 read release" : "R5 write drive",
                          cap_oe, cur.oe);
                    if (!cur.rd)
                        check(cap_v[17:0] == cur.bits[17:0], "R5 turnaround and data",
                              64'(cap_v[17:0]), 64'(cur.bits[17:0]));
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 64'(1), 64'(0));
        finish_run();
    end

    initial begin
        logic [15:0] v;
        realtime t0, t1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        rd(2'd3, v);
        check(v == 16'h0, "R1 control after reset", 64'(v), 64'h0);
        check(mdc == 1'b0 || mdc == 1'b1, "R1 mdc defined", 64'(mdc), 64'(0));
        check(mdio_oe == 1'b0, "R1 line released", 64'(mdio_oe), 64'(0));

        wr(2'd0, 16'hFFFF);
        rd(2'd0, v);
        check(v == 16'h07FF, "R2 target slot width", 64'(v), 64'h7FF);
        wr(2'd1, 16'hBEEF);
        rd(2'd1, v);
        check(v == 16'hBEEF, "R2 write value slot", 64'(v), 64'hBEEF);

        @(posedge mdc); t0 = $realtime;
        @(posedge mdc); t1 = $realtime;
        check((t1 - t0) == DIV * PERIOD, "R9 mdc period", 64'(int'(t1 - t0)), 64'(DIV * PERIOD));

        // R3: start without enable is ignored
        wr(2'd3, 16'h0001);
        rd(2'd3, v);
        check(v[0] == 1'b0, "R3 no busy without enable", 64'(v), 64'h0);
        repeat (4 * DIV * 4) @(negedge clk);
        check(mdio_oe == 1'b0, "R3 line stays released", 64'(mdio_oe), 64'(0));
        rd(2'd3, v);
        check(v == 16'h0, "R3 control still idle", 64'(v), 64'h0);

        wr(2'd3, 16'h0008);
        rd(2'd3, v);
        check(v == 16'h0008, "R3 enable alone does not start", 64'(v), 64'h8);

        txn(1'b0, 5'h01, 5'h00, 16'hA55A, 16'h0);
        txn(1'b1, 5'h1F, 5'h02, 16'h0, 16'h8001);
        txn(1'b0, 5'h10, 5'h1F, 16'h0001, 16'h0);
        txn(1'b1, 5'h00, 5'h15, 16'h0, 16'h7E3C);
        txn(1'b1, 5'h0A, 5'h04, 16'h0, 16'hFFFF);

        repeat (4 * DIV) @(negedge clk);
        check(exp_q.size() == 0, "R4 all frames seen", 64'(exp_q.size()), 64'(0));
        finish_run();
    end
endmodule